// File: doc/BRIEF.md
# Second-Order Wave Allpass Section with a Three-Port Parallel Adaptor

This block computes one second-order allpass section of a lattice wave digital filter. A single three-port parallel adaptor does all of the arithmetic. Two of its ports are closed through unit-delay state registers; the second register's value is fed back with its sign inverted. The third port takes the section input and produces the section output. Two constant adaptor weights set the pole and zero positions. Each weight is applied by a shift-and-add network built from the canonical signed-digit form of the constant, so the design contains no general multiplier.

An enable pulse presents one input sample. The section captures it, updates both state registers and registers one output sample. The output is marked valid in the following cycle. Internal sums are computed with guard bits. The state and output words are then brought back to the data width with saturation rather than wrap. Sections of this kind are cascaded in the two branches of a lattice filter. Each feedback loop holds only one weighted term, so the loop is short.

Top module: `ap2_parallel_section`

## Requirements
- R1: While `rst_n` is low, and until the first enable after it rises, `y` reads 0 and `y_vld` is low. Both state registers reset to 0.
- R2: Each cycle with `en` high produces exactly one result. `y_vld` is high in the following cycle and is low in the cycle after any cycle with `en` low.
- R3: With state words s1, s2 and input x (all signed 16-bit), the node value is a0 = floor((1024·x + 653·(s1 − x) + 134·(−s2 − x)) / 512). This uses weights β1 = 653/512 and β2 = 134/512, with 9 fraction bits.
- R4: The registered output is y = sat(x − a0).
- R5: On an enabled cycle the state registers take s1 ← sat(a0 − s1) and s2 ← sat(a0 + s2).
- R6: sat() clamps to the range −32768 to 32767 and never wraps. A long full-scale constant input drives the second state word into this clamp.
- R7: With `en` low, the output and both state words keep their values whatever `x` does.
- R8: Starting from rest, the impulse response follows H(z) = (c + d·z⁻¹ − z⁻²)/(−1 + d·z⁻¹ + c·z⁻²) within 12 LSB over 32 samples, where c = 1 − β1 − β2 and d = β1 − β2.
- R9: With zero state and zero input, the output and state stay exactly zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Sample strobe: accept `x` this cycle |
| x | input | 16 | Input sample, signed two's complement |
| y | output | 16 | Output sample, signed, registered |
| y_vld | output | 1 | `y` holds a new sample |

## Verification
The hardest condition to reach from the ports is clamping inside the recursion. An allpass keeps unit gain at its output, so ordinary input never overflows `y`, yet a state word can exceed full scale while the output stays in range. At DC the second state settles near 1.77 times the input. The stimulus therefore holds the input at positive and then negative full scale for tens of samples, and follows this with a full-scale square wave near the pole angle. The bit-exact scoreboard tracks every clamp, and the bench confirms that its model recorded at least one.

// File: rtl/ap2_pkg.sv
package ap2_pkg;

  // Canonical signed-digit recoding of a non-negative constant.
  // Returns {negative digit mask, positive digit mask}, 32 positions each.
  function automatic logic [63:0] csd_digits(input int k);
    logic [31:0] pos;
    logic [31:0] neg;
    int          r;
    pos = '0;
    neg = '0;
    r   = k;
    for (int i = 0; i < 32; i++) begin
      if ((r & 1) != 0) begin
        if ((r & 3) == 1) begin
          pos[i] = 1'b1;
          r      = r - 1;
        end else begin
          neg[i] = 1'b1;
          r      = r + 1;
        end
      end
      r = r >>> 1;
    end
    return {neg, pos};
  endfunction

  // Clamp a wide signed value to a w-bit two's-complement range.
  function automatic longint clamp_to(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/ap2_csd_mult.sv
module ap2_csd_mult #(
  parameter int IN_W  = 18,
  parameter int KW    = 10,
  parameter int K     = 1,
  parameter int OUT_W = IN_W + KW + 1
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic [63:0] DIG = ap2_pkg::csd_digits(K);
  localparam int          ND  = KW + 1;

  logic signed [OUT_W-1:0] din_ext;
  logic signed [OUT_W-1:0] term [ND];

  assign din_ext = OUT_W'(din);

  for (genvar i = 0; i < ND; i++) begin : g_digit
    if (DIG[i]) begin : g_pos
      assign term[i] = din_ext <<< i;
    end else if (DIG[32+i]) begin : g_neg
      assign term[i] = -(din_ext <<< i);
    end else begin : g_zero
      assign term[i] = '0;
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < ND; i++) begin
      dout = dout + term[i];
    end
  end
endmodule

// File: rtl/ap2_adaptor3.sv
module ap2_adaptor3 #(
  parameter int W     = 16,
  parameter int CB    = 10,
  parameter int FRAC  = 9,
  parameter int BETA1 = 653,
  parameter int BETA2 = 134,
  parameter int AW    = W + CB + 5
) (
  input  logic signed [W-1:0]  x,
  input  logic signed [W-1:0]  s1,
  input  logic signed [W-1:0]  s2,
  output logic signed [AW-1:0] a0,
  output logic signed [AW-1:0] b1_raw,
  output logic signed [AW-1:0] b2_raw,
  output logic signed [AW-1:0] y_raw
);
  localparam int EW = W + 2;
  localparam int PW = EW + CB + 1;

  logic signed [EW-1:0] diff1;
  logic signed [EW-1:0] diff2;
  logic signed [PW-1:0] prod1;
  logic signed [PW-1:0] prod2;
  logic signed [AW-1:0] acc;

  // port 1 sees s1, port 2 sees -s2; both referenced to the input port
  assign diff1 = EW'(s1) - EW'(x);
  assign diff2 = -EW'(s2) - EW'(x);

  ap2_csd_mult #(.IN_W(EW), .KW(CB), .K(BETA1), .OUT_W(PW)) u_mul1 (
    .din (diff1),
    .dout(prod1)
  );

  ap2_csd_mult #(.IN_W(EW), .KW(CB), .K(BETA2), .OUT_W(PW)) u_mul2 (
    .din (diff2),
    .dout(prod2)
  );

  assign acc    = (AW'(x) <<< (FRAC + 1)) + AW'(prod1) + AW'(prod2);
  assign a0     = acc >>> FRAC;
  assign b1_raw = a0 - AW'(s1);
  assign b2_raw = a0 + AW'(s2);
  assign y_raw  = AW'(x) - a0;
endmodule

// File: rtl/ap2_sat.sv
module ap2_sat #(
  parameter int IN_W  = 31,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout,
  output logic                    clip
);
  localparam logic signed [IN_W-1:0] HI = IN_W'((longint'(1) <<< (OUT_W - 1)) - 1);
  localparam logic signed [IN_W-1:0] LO = IN_W'(-(longint'(1) <<< (OUT_W - 1)));

  always_comb begin
    clip = 1'b0;
    dout = din[OUT_W-1:0];
    if (din > HI) begin
      clip = 1'b1;
      dout = HI[OUT_W-1:0];
    end else if (din < LO) begin
      clip = 1'b1;
      dout = LO[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/ap2_parallel_section.sv
module ap2_parallel_section #(
  parameter int W     = 16,
  parameter int CB    = 10,
  parameter int FRAC  = 9,
  parameter int BETA1 = 653,
  parameter int BETA2 = 134
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y,
  output logic                y_vld
);
  localparam int AW = W + CB + 5;

  logic signed [W-1:0]  s1_q;
  logic signed [W-1:0]  s2_q;
  logic signed [W-1:0]  y_q;
  logic                 vld_q;
  logic signed [AW-1:0] a0;
  logic signed [AW-1:0] b1_raw;
  logic signed [AW-1:0] b2_raw;
  logic signed [AW-1:0] y_raw;
  logic signed [W-1:0]  s1_next;
  logic signed [W-1:0]  s2_next;
  logic signed [W-1:0]  y_next;
  logic                 s1_clip;
  logic                 s2_clip;
  logic                 y_clip;

  ap2_adaptor3 #(
    .W(W), .CB(CB), .FRAC(FRAC), .BETA1(BETA1), .BETA2(BETA2), .AW(AW)
  ) u_adaptor (
    .x     (x),
    .s1    (s1_q),
    .s2    (s2_q),
    .a0    (a0),
    .b1_raw(b1_raw),
    .b2_raw(b2_raw),
    .y_raw (y_raw)
  );

  ap2_sat #(.IN_W(AW), .OUT_W(W)) u_sat_s1 (.din(b1_raw), .dout(s1_next), .clip(s1_clip));
  ap2_sat #(.IN_W(AW), .OUT_W(W)) u_sat_s2 (.din(b2_raw), .dout(s2_next), .clip(s2_clip));
  ap2_sat #(.IN_W(AW), .OUT_W(W)) u_sat_y  (.din(y_raw),  .dout(y_next),  .clip(y_clip));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en;
      if (en) begin
        s1_q <= s1_next;
        s2_q <= s2_next;
        y_q  <= y_next;
      end
    end
  end

  assign y     = y_q;
  assign y_vld = vld_q;
endmodule

// File: rtl/ap2_section_chk.sv
module ap2_section_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic signed [W-1:0] x,
  input logic signed [W-1:0] y,
  input logic                y_vld,
  input logic signed [W-1:0] s1,
  input logic signed [W-1:0] s2,
  input logic                s1_clip,
  input logic                s2_clip
);
  localparam logic signed [W-1:0] HI = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] LO = {1'b1, {(W-1){1'b0}}};

  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n) en |=> y_vld);
  p_novalid_r2: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !y_vld);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(y) && $stable(s1) && $stable(s2)));
  p_clip_s1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s1_clip) |=> (s1 == HI || s1 == LO));
  p_clip_s2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s2_clip) |=> (s2 == HI || s2 == LO));
  p_zero_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && x == '0 && s1 == '0 && s2 == '0) |=> (y == '0 && s1 == '0 && s2 == '0));
endmodule

bind ap2_parallel_section ap2_section_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .x      (x),
  .y      (y),
  .y_vld  (y_vld),
  .s1     (s1_q),
  .s2     (s2_q),
  .s1_clip(s1_clip),
  .s2_clip(s2_clip)
);

// File: tb/test_ap2_parallel_section.sv
`timescale 1ns/1ps
module test_ap2_parallel_section;
  localparam longint B1 = 653;
  localparam longint B2 = 134;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b0;
  logic signed [15:0] x = '0;
  logic signed [15:0] y;
  logic               y_vld;

  int     nchk = 0;
  int     nfail = 0;
  int     npush = 0;
  int     npop = 0;
  int     nclip = 0;
  longint ms1 = 0;
  longint ms2 = 0;
  longint expq[$];
  longint got[$];
  bit     rec = 1'b0;
  string  tag = "R3 R4 R5";
  bit     done = 1'b0;

  always #2.5 clk = ~clk;

  ap2_parallel_section i_ap2_parallel_section (
    .clk(clk), .rst_n(rst_n), .en(en), .x(x), .y(y), .y_vld(y_vld)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint clampv(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // scoreboard driver: model per R3..R6, then present the sample
  task automatic push(input longint xv);
    longint acc, a0, nb1, nb2, yv;
    acc = 1024 * xv + B1 * (ms1 - xv) + B2 * (-ms2 - xv);
    a0  = acc >>> 9;
    nb1 = clampv(a0 - ms1);
    nb2 = clampv(a0 + ms2);
    yv  = clampv(xv - a0);
    if (nb1 != a0 - ms1) nclip++;
    if (nb2 != a0 + ms2) nclip++;
    ms1 = nb1;
    ms2 = nb2;
    expq.push_back(yv);
    npush++;
    @(negedge clk);
    x  = 16'(xv);
    en = 1'b1;
  endtask

  task automatic drain();
    @(negedge clk);
    en = 1'b0;
    while (expq.size() != 0) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && y_vld) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2", longint'(y), 0);
      end else begin
        longint e;
        e = expq.pop_front();
        npop++;
        check(longint'(y) == e, tag, longint'(y), e);
        if (rec) got.push_back(longint'(y));
      end
    end
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    longint hold_y;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(y == 0, "R1", longint'(y), 0);
    check(y_vld == 1'b0, "R1", longint'(y_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(y == 0, "R1", longint'(y), 0);
    check(y_vld == 1'b0, "R1", longint'(y_vld), 0);

    // R8 impulse response from rest
    tag = "R3 R4 R5 R8";
    rec = 1'b1;
    push(8192);
    for (int n = 1; n < 32; n++) push(0);
    drain();
    rec = 1'b0;
    begin
      real d, c, yr, y1, y2, x1, x2, xn;
      d = real'(B1 - B2) / 512.0;
      c = 1.0 - real'(B1 + B2) / 512.0;
      y1 = 0.0; y2 = 0.0; x1 = 0.0; x2 = 0.0;
      for (int n = 0; n < 32; n++) begin
        real df;
        xn = (n == 0) ? 8192.0 : 0.0;
        yr = d * y1 + c * y2 - c * xn - d * x1 + x2;
        df = real'(got[n]) - yr;
        if (df < 0.0) df = -df;
        check(df <= 12.0, "R8", got[n], longint'(yr));
        y2 = y1; y1 = yr; x2 = x1; x1 = xn;
      end
    end

    // R7 hold with enable low
    tag = "R3 R4 R5 R7";
    push(1000);
    push(-2500);
    drain();
    hold_y = longint'(y);
    for (int k = 0; k < 6; k++) begin
      x = 16'(5000 + 1234 * k);
      @(negedge clk);
      check(longint'(y) == hold_y, "R7", longint'(y), hold_y);
      check(y_vld == 1'b0, "R2", longint'(y_vld), 0);
    end
    push(300);   // exact compare proves the states were untouched
    drain();

    // varied input pattern
    tag = "R3 R4 R5";
    lf = 16'hACE1;
    for (int k = 0; k < 200; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      push(longint'($signed(lf)) / 2);
    end
    drain();

    // R9 zero rest after a fresh reset
    @(negedge clk);
    rst_n = 1'b0;
    ms1 = 0; ms2 = 0;
    @(negedge clk);
    check(y == 0, "R1", longint'(y), 0);
    rst_n = 1'b1;
    tag = "R9";
    for (int k = 0; k < 10; k++) push(0);
    drain();

    // R6 saturation in the recursion
    tag = "R6";
    for (int k = 0; k < 40; k++) push(32767);
    for (int k = 0; k < 40; k++) push(-32768);
    for (int k = 0; k < 64; k++) push(((k / 4) % 2 == 0) ? 32767 : -32768);
    drain();
    check(nclip > 0, "R6", nclip, 1);

    // R2 one result per enable
    repeat (3) @(negedge clk);
    check(npush == npop, "R2", npop, npush);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule